// File: doc/BRIEF.md
# Hibernate and Wakeup Sequencer

This block sits in the always-on timekeeping clock domain and decides when the rest of the chip gets power. While running it holds its power-enable output high and its active-low system reset output released. A write to the hibernate command register removes power and holds the system in reset. The block then watches an external wakeup pin. Power returns only after that pin has stayed high without a break for a programmable number of clock ticks. Once power is back, the system reset output stays low for a second programmable number of ticks and is then released.

The two tick counts are kept in register fields whose five least significant bits always read as zero. The counts therefore step in units of 32 ticks. The wakeup pin passes through a two-flop synchroniser before it is filtered. Any low sample during filtering sends the block back to waiting and clears the count. It does not resume from where it stopped.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset, pwr_en is 1, sys_rst_n is 1, and reads of the wakeup-filter register (address 0x24) and the reset-hold register (address 0x28) return 0.
- R2: A write to address 0x24 stores write-data bits 15:5 as the filter field. A read of 0x24 returns the write data ANDed with 0x0000FFE0, and all other bits read 0.
- R3: A write to address 0x28 stores write-data bits 11:5 as the hold field. A read of 0x28 returns the write data ANDed with 0x00000FE0, and all other bits read 0.
- R4: While running, a write to address 0x20 with bit 0 set drives pwr_en and sys_rst_n low from the clock edge that takes the write. A write to 0x20 with bit 0 clear has no effect.
- R5: While power is off, sys_rst_n stays low. A low wakeup pin sample during filtering discards the count gathered so far, so a later high period is timed from its own start.
- R6: Let F be the filter field times 32. Wakeup is accepted only if wake_pin is sampled high on at least F+2 consecutive rising edges. pwr_en rises after edge F+3, counted from edge 0, the first edge that samples the pin high.
- R7: Let H be the hold field times 32. After pwr_en rises, sys_rst_n stays low for exactly H+1 clock cycles and then goes high.
- R8: A hibernate command written while filtering or holding reset is ignored. The block completes its reset hold and returns to the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping-domain clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| wake_pin | input | 1 | Asynchronous active-high wakeup request |
| pwr_en | output | 1 | Power enable for the switched domain |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The hardest case to reach is the point where the pin drops after exactly F+1 high samples. That is one sample short of acceptance. The synchroniser delay makes this off-by-one easy to misjudge from the ports. The stimulus drives pulses of F+1 and F+2 edges to probe both sides of the threshold. It also drives trains of random short pulses separated by one to three low cycles, each followed by a full hold, so the latency shows whether the count was really cleared. A hibernate command issued in the middle of the reset hold covers the path where the command arrives while the block is not running.

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 5,
  parameter int FILT_BITS = 11,
  parameter int HOLD_BITS = 7,
  parameter int HIB_ADDR  = 'h20,
  parameter int FILT_ADDR = 'h24,
  parameter int HOLD_ADDR = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wake_pin,
  output logic              pwr_en,
  output logic              sys_rst_n
);
  localparam int WIDE_BITS = (FILT_BITS > HOLD_BITS) ? FILT_BITS : HOLD_BITS;
  localparam int CNT_W     = FIELD_LSB + WIDE_BITS;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_FILT, ST_HOLD} state_t;

  state_t               st;
  logic [CNT_W-1:0]     cnt;
  logic [FILT_BITS-1:0] filt_q;
  logic [HOLD_BITS-1:0] hold_q;
  logic [1:0]           sync_q;

  wire wake_s  = sync_q[1];
  wire sel_hib = reg_addr == ADDR_W'(HIB_ADDR);
  wire sel_flt = reg_addr == ADDR_W'(FILT_ADDR);
  wire sel_hld = reg_addr == ADDR_W'(HOLD_ADDR);
  wire go_hib  = reg_wr && sel_hib && reg_wdata[0];

  wire [CNT_W-1:0] filt_lim = CNT_W'({filt_q, {FIELD_LSB{1'b0}}});
  wire [CNT_W-1:0] hold_lim = CNT_W'({hold_q, {FIELD_LSB{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      hold_q <= '0;
    end else if (reg_wr) begin
      if (sel_flt) filt_q <= reg_wdata[FIELD_LSB +: FILT_BITS];
      if (sel_hld) hold_q <= reg_wdata[FIELD_LSB +: HOLD_BITS];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_flt) reg_rdata[FIELD_LSB +: FILT_BITS] = filt_q;
    if (sel_hld) reg_rdata[FIELD_LSB +: HOLD_BITS] = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], wake_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          cnt <= '0;
          if (go_hib) st <= ST_SLEEP;
        end
        ST_SLEEP: begin
          cnt <= '0;
          if (wake_s) st <= ST_FILT;
        end
        ST_FILT: begin
          if (!wake_s) begin
            st  <= ST_SLEEP;
            cnt <= '0;
          end else if (cnt >= filt_lim) begin
            st  <= ST_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt >= hold_lim) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign pwr_en    = (st == ST_RUN) || (st == ST_HOLD);
  assign sys_rst_n = (st == ST_RUN);
endmodule

module hib_wake_seq_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int HIB_ADDR = 'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              wake_pin,
  input logic              pwr_en,
  input logic              sys_rst_n
);
  wire cmd = reg_wr && (reg_addr == ADDR_W'(HIB_ADDR)) && reg_wdata[0];

  AST_OFF_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !sys_rst_n); // R5
  AST_CMD_DROPS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && sys_rst_n) |=> (!pwr_en && !sys_rst_n)); // R4
  AST_FALL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(cmd)); // R4
  AST_WAKE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(wake_pin, 3)); // R6
  AST_RELEASE_AFTER_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (pwr_en && $past(pwr_en))); // R7
  AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && !cmd) |=> sys_rst_n); // R8
endmodule

bind hib_wake_seq hib_wake_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIB_ADDR(HIB_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .wake_pin(wake_pin), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n));

// File: tb/sim_hib_wake_seq.sv
module sim_hib_wake_seq;
  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, wake_pin = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        pwr_en, sys_rst_n;
  int checks = 0, fails = 0;

  localparam logic [5:0] A_HIB = 6'h20, A_FLT = 6'h24, A_HLD = 6'h28;

  always #10 clk = ~clk;

  hib_wake_seq u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_pin(wake_pin),
    .pwr_en(pwr_en), .sys_rst_n(sys_rst_n));

  function automatic logic [31:0] exp_flt(logic [31:0] w); return w & 32'h0000FFE0; endfunction
  function automatic logic [31:0] exp_hld(logic [31:0] w); return w & 32'h00000FE0; endfunction
  function automatic int exp_lat(int ff); return ff * 32 + 4; endfunction
  function automatic int exp_hold(int hf); return hf * 32 + 1; endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string req);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic hibernate();
    wr(A_HIB, 32'h1 | ($urandom & 32'hFFFF_FFFE));
    chk(!pwr_en && !sys_rst_n, "R4 hibernate", {pwr_en, sys_rst_n}, 0);
  endtask

  task automatic pulse(int n);
    @(negedge clk); wake_pin = 1'b1;
    repeat (n) @(negedge clk);
    wake_pin = 1'b0;
  endtask

  task automatic stay_off(int cyc, string req);
    bit bad = 0;
    repeat (cyc) begin @(negedge clk); if (pwr_en || sys_rst_n) bad = 1; end
    chk(!bad, req, bad, 0);
  endtask

  task automatic wake_meas(int ff, int hf, int hold, bit poke);
    int c = 0, d = 0;
    @(negedge clk); wake_pin = 1'b1;
    while (!pwr_en && c < 100000) begin
      @(negedge clk); c++;
      if (hold > 0 && c == hold) wake_pin = 1'b0;
      if (!pwr_en && sys_rst_n) c = 100000;
    end
    chk(c == exp_lat(ff), "R6 wake latency", c, exp_lat(ff));
    if (poke) begin reg_wr = 1'b1; reg_addr = A_HIB; reg_wdata = 32'h1; end
    while (!sys_rst_n && d < 100000) begin
      @(negedge clk); d++;
      if (d == 1) reg_wr = 1'b0;
      if (d >= 1 && c >= hold && hold > 0) wake_pin = 1'b0;
    end
    wake_pin = 1'b0;
    chk(d == exp_hold(hf), "R7 reset hold", d, exp_hold(hf));
    if (poke) begin
      @(negedge clk);
      chk(pwr_en && sys_rst_n, "R8 command ignored in hold", {pwr_en, sys_rst_n}, 2'b11);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwr_en && sys_rst_n, "R1 reset outputs", {pwr_en, sys_rst_n}, 2'b11);
    rd_chk(A_FLT, 0, "R1 filter reset");
    rd_chk(A_HLD, 0, "R1 hold reset");

    wr(A_FLT, 32'hFFFF_FFFF); rd_chk(A_FLT, exp_flt(32'hFFFF_FFFF), "R2 filter mask");
    wr(A_HLD, 32'hFFFF_FFFF); rd_chk(A_HLD, exp_hld(32'hFFFF_FFFF), "R3 hold mask");
    wr(A_FLT, 32'h0000_001F); rd_chk(A_FLT, 0, "R2 low bits");

    wr(A_HIB, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    chk(pwr_en && sys_rst_n, "R4 bit0 clear no effect", {pwr_en, sys_rst_n}, 2'b11);

    // directed: F=32, H=64, boundary and restart
    wr(A_FLT, 32'h20); wr(A_HLD, 32'h40);
    hibernate();
    pulse(33);
    stay_off(45, "R6 F+1 edges rejected");
    pulse(33);
    wake_meas(1, 2, 0, 0); // R5 restart after 1-cycle gap

    // F=0, H=0
    wr(A_FLT, 32'h0); wr(A_HLD, 32'h0);
    hibernate();
    pulse(1);
    stay_off(8, "R6 single edge rejected");
    wake_meas(0, 0, 2, 0);

    // command during reset hold
    wr(A_HLD, 32'h60);
    hibernate();
    wake_meas(0, 3, 0, 1);

    // random
    for (int it = 0; it < 20; it++) begin
      int ff = $urandom_range(0, 4);
      int hf = $urandom_range(0, 4);
      int np = $urandom_range(0, 3);
      logic [31:0] wf = ($urandom & ~32'h0000FFE0) | (ff << 5);
      logic [31:0] wh = ($urandom & ~32'h00000FE0) | (hf << 5);
      wr(A_FLT, wf); rd_chk(A_FLT, exp_flt(wf), "R2 random readback");
      wr(A_HLD, wh); rd_chk(A_HLD, exp_hld(wh), "R3 random readback");
      hibernate();
      for (int p = 0; p < np; p++) begin
        pulse($urandom_range(1, ff * 32 + 1));
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      stay_off(ff * 32 + 6, "R5 short pulses keep power off");
      wake_meas(ff, hf, ($urandom_range(0, 1) == 1) ? ff * 32 + 2 + $urandom_range(0, 8) : 0, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule